// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width-modulated output from a 20-bit up or up/down counter. Software sets it up through five 32-bit registers: a mode word, a duty value, a period value, a read-only live counter and an update word. The mode word picks the count rate, the waveform alignment and the output polarity. The rate is the master clock slowed by a power of two, or one of two divided clocks that reach the block as one-cycle enable pulses.

While the channel runs, changing the period or duty directly can produce a malformed cycle. The safe path is the update word. A mode bit decides whether it is aimed at the period or at the duty. The value is held until the current cycle ends and is copied in at the boundary. A one-cycle event pulse marks every boundary, so software knows when the copy has happened.

The `run` input starts and stops waveform generation. Stopping clears the counter and parks the output at its idle level. Restarting counts from zero with whatever the registers hold.

Top module: `pwm_chan`

## Requirements
- R1: After reset the mode, duty, period, counter and update registers all read 0, `pwm_out` is 0 and `period_evt` is 0.
- R2: Register offsets are mode 0x00, duty 0x04, period 0x08, counter 0x0C and update 0x10. Mode keeps bits [10:0] and reads back zero above them. Update reads back the last value written to it. Writes to the counter offset are ignored. Reads of any other offset return 0.
- R3: Mode bits [3:0] hold the clock select code n. For n from 0 to 10 the counter steps once every 2^n master clocks. Code 0xB steps on `clka_tick` and code 0xC steps on `clkb_tick`. Codes 0xD to 0xF stop the counter, and no period event occurs.
- R4: With mode bit 8 clear (left aligned), the counter runs 0, 1, ..., P-1 and then returns to 0. A cycle is P steps long and the output is active for the D steps in which counter < D.
- R5: With mode bit 8 set (center aligned), the counter runs 0 up to P and back down to 1, so a cycle is 2P steps. The output is active for 2D-1 steps when D ≥ 1 and for no steps when D = 0.
- R6: Mode bit 9 sets the idle level of `pwm_out`: 1 when the bit is set, 0 when it is clear. The active level is the inverse of the idle level.
- R7: The duty never exceeds the period. A duty value larger than the period is stored as the period. A period smaller than the current duty pulls the duty down to the new period.
- R8: A write to the update offset is applied at the next cycle boundary and never earlier. At that boundary it goes to the period if mode bit 10 is set, and to the duty if the bit is clear.
- R9: `period_evt` is high for one clock cycle after each cycle boundary, and in that cycle the counter reads 0.
- R10: While `run` is low the counter reads 0, `pwm_out` is at the idle level and no period event occurs. Raising `run` restarts counting from 0 using the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel enable; low stops and clears the counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clka_tick | input | 1 | One-cycle enable pulse of divided clock A |
| clkb_tick | input | 1 | One-cycle enable pulse of divided clock B |
| pwm_out | output | 1 | Waveform output |
| period_evt | output | 1 | One-cycle pulse after each cycle boundary |

## Verification
The assertions rely on these input conditions:
- `clka_tick` and `clkb_tick` are single-cycle pulses in the master clock domain.
- `bus_addr` is stable while `bus_wr` is high.

The bench drives every input at the falling clock edge, so each write and each tick pulse lasts exactly one cycle. The A and B pulses come from fixed divide-by-3 and divide-by-5 generators, so a cycle's expected length in clocks is known in advance. Registers are loaded with `run` low, except in the update tests, which write the update word in the middle of a running cycle.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    // register offsets (byte addresses)
    localparam logic [4:0] OFS_MODE = 5'h00;
    localparam logic [4:0] OFS_DUTY = 5'h04;
    localparam logic [4:0] OFS_PRD  = 5'h08;
    localparam logic [4:0] OFS_CNT  = 5'h0C;
    localparam logic [4:0] OFS_UPD  = 5'h10;

    // mode word layout
    localparam int MODE_W     = 11;
    localparam int MB_CENTER  = 8;
    localparam int MB_IDLEHI  = 9;
    localparam int MB_UPD_PRD = 10;
    localparam int PRE_MAX    = 10;

    // clock select codes above the power-of-two range
    localparam logic [3:0] CSEL_EXT_A = 4'hB;
    localparam logic [3:0] CSEL_EXT_B = 4'hC;
endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
    import pwm_chan_pkg::*;
#(
    parameter int PRE_W = PRE_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] csel,
    input  logic       clka_tick,
    input  logic       clkb_tick,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;

    always_comb begin
        pre_d  = pre_q + PRE_W'(1);
        one_sh = (PRE_W+1)'(1) << csel;
        mask   = one_sh[PRE_W-1:0] - PRE_W'(1);
        if (32'(csel) <= PRE_W)  tick = &(pre_q | ~mask);
        else if (csel == CSEL_EXT_A) tick = clka_tick;
        else if (csel == CSEL_EXT_B) tick = clkb_tick;
        else                     tick = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3
    ext_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csel == CSEL_EXT_A) |-> (tick == clka_tick));
endmodule

// File: rtl/pwm_wave_ctr.sv
module pwm_wave_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             bnd,
    output logic             evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             evt;
    } ctr_t;

    ctr_t s_d, s_q;
    logic at_end;

    always_comb begin
        if (center)
            at_end = (s_q.down && s_q.cnt <= CNT_W'(1)) ||
                     (!s_q.down && s_q.cnt >= prd && prd <= CNT_W'(1));
        else
            at_end = ({1'b0, s_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, prd};
        bnd = run && tick && at_end;

        s_d     = s_q;
        s_d.evt = bnd;
        if (!run || bnd) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
        end else if (tick) begin
            if (center && !s_q.down && s_q.cnt >= prd) begin
                s_d.down = 1'b1;
                s_d.cnt  = s_q.cnt - CNT_W'(1);
            end else if (center && s_q.down) begin
                s_d.cnt  = s_q.cnt - CNT_W'(1);
            end else begin
                s_d.cnt  = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign evt = s_q.evt;

    // R9
    evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt |-> (s_q.cnt == '0));
    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0 && !s_q.evt));
    // R3
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(s_q.cnt));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clka_tick,
    input  logic              clkb_tick,
    output logic              pwm_out,
    output logic              period_evt
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  dty;
        logic [CNT_W-1:0]  prd;
        logic [CNT_W-1:0]  upd;
        logic              pend;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, bnd, idle_hi;
    logic [CNT_W-1:0] cnt;

    pwm_tick_sel #(.PRE_W(PRE_MAX)) u_tick (
        .clk(clk), .rst_n(rst_n), .csel(r_q.mode[3:0]),
        .clka_tick(clka_tick), .clkb_tick(clkb_tick), .tick(tick)
    );

    pwm_wave_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .center(r_q.mode[MB_CENTER]), .prd(r_q.prd),
        .cnt(cnt), .bnd(bnd), .evt(period_evt)
    );

    always_comb begin
        r_d = r_q;
        // buffered update lands only at a boundary
        if (bnd && r_q.pend) begin
            if (r_q.mode[MB_UPD_PRD]) r_d.prd = r_q.upd;
            else                      r_d.dty = r_q.upd;
            r_d.pend = 1'b0;
        end
        if (bus_wr) begin
            case (5'(bus_addr))
                OFS_MODE: r_d.mode = bus_wdata[MODE_W-1:0];
                OFS_DUTY: r_d.dty  = bus_wdata[CNT_W-1:0];
                OFS_PRD:  r_d.prd  = bus_wdata[CNT_W-1:0];
                OFS_UPD: begin
                    r_d.upd  = bus_wdata[CNT_W-1:0];
                    r_d.pend = 1'b1;
                end
                default: ;
            endcase
        end
        if (r_d.dty > r_d.prd) r_d.dty = r_d.prd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (5'(bus_addr))
            OFS_MODE: bus_rdata = DATA_W'(r_q.mode);
            OFS_DUTY: bus_rdata = DATA_W'(r_q.dty);
            OFS_PRD:  bus_rdata = DATA_W'(r_q.prd);
            OFS_CNT:  bus_rdata = DATA_W'(cnt);
            OFS_UPD:  bus_rdata = DATA_W'(r_q.upd);
            default:  bus_rdata = '0;
        endcase
    end

    assign idle_hi = r_q.mode[MB_IDLEHI];
    assign pwm_out = run ? ((cnt < r_q.dty) ^ idle_hi) : idle_hi;

    // R7
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dty <= r_q.prd);
    // R8
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bnd && !(bus_wr && 5'(bus_addr) == OFS_PRD)) |=> $stable(r_q.prd));
endmodule

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clka_tick = 1'b0, clkb_tick = 1'b0;
    logic        pwm_out, period_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_chan u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clka_tick(clka_tick), .clkb_tick(clkb_tick),
        .pwm_out(pwm_out), .period_evt(period_evt)
    );

    // divided clock pulses: A every 3 clocks, B every 5 clocks
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            clka_tick = (ph % 3 == 0);
            clkb_tick = (ph % 5 == 0);
        end
    end

    // mode, period, duty, expected cycle length (clocks), expected active clocks
    localparam int NV = 8;
    localparam int V_MODE [NV] = '{'h000, 'h000, 'h000, 'h200, 'h100, 'h300, 'h002, 'h101};
    localparam int V_PRD  [NV] = '{5, 8, 6, 5, 4, 3, 3, 2};
    localparam int V_DTY  [NV] = '{2, 8, 0, 3, 2, 3, 1, 1};
    localparam int V_LEN  [NV] = '{5, 8, 6, 5, 8, 6, 12, 8};
    localparam int V_ACT  [NV] = '{2, 8, 0, 3, 3, 5, 4, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // waits for an event, then measures one cycle from event to event
    task automatic measure(input bit idle, output int len, output int act);
        int guard = 0;
        len = 0; act = 0;
        @(negedge clk);
        while (!period_evt && guard < 3000) begin @(negedge clk); guard++; end
        do begin
            if (pwm_out != idle) act++;
            len++;
            @(negedge clk);
        end while (!period_evt && len < 3000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, len, act, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(5'h00, v); chk(v == 0, "R1 mode", v, 0);
        rd(5'h04, v); chk(v == 0, "R1 duty", v, 0);
        rd(5'h08, v); chk(v == 0, "R1 period", v, 0);
        rd(5'h0C, v); chk(v == 0, "R1 counter", v, 0);
        rd(5'h10, v); chk(v == 0, "R1 update", v, 0);
        chk(pwm_out == 0 && period_evt == 0, "R1 outputs", {pwm_out, period_evt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register map
        wr(5'h00, 32'hFFFF_F8F3);
        rd(5'h00, v); chk(v == 'h0F3, "R2 mode width", v, 'h0F3);
        wr(5'h10, 77);
        rd(5'h10, v); chk(v == 77, "R2 update readback", v, 77);
        wr(5'h0C, 123);
        rd(5'h0C, v); chk(v == 0, "R2 counter write ignored", v, 0);
        wr(5'h14, 55);
        rd(5'h14, v); chk(v == 0, "R2 unmapped read", v, 0);
        rd(5'h18, v); chk(v == 0, "R2 unmapped read 18", v, 0);
        // the pending update from above is harmless: it is replaced before each run
        wr(5'h00, 0);

        // vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            run = 1'b0;
            wr(5'h00, V_MODE[i]);
            wr(5'h08, V_PRD[i]);
            wr(5'h04, V_DTY[i]);
            wr(5'h10, V_DTY[i]);           // pending update aims at duty, same value
            run = 1'b1;
            measure(V_MODE[i][9], len, act);
            measure(V_MODE[i][9], len, act);
            chk(len == V_LEN[i], $sformatf("R4/R5/R3 length vec%0d", i), len, V_LEN[i]);
            chk(act == V_ACT[i], $sformatf("R4/R5/R6 active vec%0d", i), act, V_ACT[i]);
            run = 1'b0;
        end

        // R6 idle level while stopped
        wr(5'h00, 'h200);
        #1 chk(pwm_out == 1, "R6 idle high", pwm_out, 1);
        wr(5'h00, 'h000);
        #1 chk(pwm_out == 0, "R6 idle low", pwm_out, 0);

        // R7 duty clamp
        wr(5'h08, 4);
        wr(5'h04, 9);
        rd(5'h04, v); chk(v == 4, "R7 duty capped", v, 4);
        wr(5'h08, 2);
        rd(5'h04, v); chk(v == 2, "R7 duty follows period", v, 2);

        // R8 update to duty, then to period
        wr(5'h08, 5); wr(5'h04, 1);
        run = 1'b1;
        measure(1'b0, len, act);
        wr(5'h10, 3);
        rd(5'h04, v); chk(v == 1, "R8 duty not early", v, 1);
        while (!period_evt) @(negedge clk);
        rd(5'h04, v); chk(v == 3, "R8 duty at boundary", v, 3);
        wr(5'h00, 'h400);
        wr(5'h10, 7);
        rd(5'h08, v); chk(v == 5, "R8 period not early", v, 5);
        while (!period_evt) @(negedge clk);
        rd(5'h08, v); chk(v == 7, "R8 period at boundary", v, 7);
        rd(5'h04, v); chk(v == 3, "R8 duty untouched", v, 3);
        measure(1'b0, len, act);
        chk(len == 7, "R8 new period length", len, 7);

        // R9 event pulse width and counter value
        n = 0;
        measure(1'b0, len, act);
        rd(5'h0C, v); chk(period_evt == 1 && v == 0, "R9 counter zero at event", v, 0);
        @(negedge clk);
        chk(period_evt == 0, "R9 one-cycle event", period_evt, 0);

        // R10 disable and restart
        @(negedge clk); @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        rd(5'h0C, v); chk(v == 0, "R10 counter cleared", v, 0);
        chk(pwm_out == 0, "R10 idle when stopped", pwm_out, 0);
        n = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (period_evt) n++; end
        chk(n == 0, "R10 no event when stopped", n, 0);
        run = 1'b1;
        rd(5'h0C, v); chk(v == 0, "R10 restart from zero", v, 0);
        chk(pwm_out == 1, "R10 active on restart", pwm_out, 1);
        @(negedge clk);
        rd(5'h0C, v); chk(v == 1, "R10 counting after restart", v, 1);
        run = 1'b0;

        // R3 external clocks and stall codes
        wr(5'h08, 4); wr(5'h04, 2);
        wr(5'h00, 'h00B);
        run = 1'b1;
        measure(1'b0, len, act); measure(1'b0, len, act);
        chk(len == 12, "R3 clock A length", len, 12);
        run = 1'b0;
        wr(5'h00, 'h00C);
        run = 1'b1;
        measure(1'b0, len, act); measure(1'b0, len, act);
        chk(len == 20, "R3 clock B length", len, 20);
        run = 1'b0;
        wr(5'h00, 'h00D);
        run = 1'b1;
        n = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (period_evt) n++; end
        rd(5'h0C, v);
        chk(v == 0 && n == 0, "R3 stall code", v + n, 0);
        run = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule